// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out one block transfer between a register file and memory, one 32-bit word per cycle. A transfer starts with a single-cycle `start` strobe. The strobe carries a 16-bit register list, a base address and the index of the base register. It also carries four mode bits: address direction, pre/post stepping, base write-back, and load or store. For stores it carries the address of the instruction that issued the transfer.

The sequencer walks the set bits of the list from the lowest index to the highest and issues one access per listed register on a valid/ready word port. Each access carries the register index. For a store, the sequencer reads the register through a combinational read port and places the data on the bus, substituting special values for the program-counter slot and the base register. For a load, it returns the memory word to the register file through a write port.

Both directions use ascending addresses that start from a computed lowest address. When the last access is accepted, the block pulses `done`. In that cycle it reports the updated base value, a write-back enable and the nominal cycle cost of the operation.

Top module: `multi_reg_xfer`

## Requirements
- R1: Listed registers are accessed in ascending index order, exactly once each, and each accepted access is followed by one at the address 4 higher.
- R2: The first access address depends on the mode bits, with n the number of set bits in the list and B the base address. Up with pre-step (upMode=1, preIndex=1) starts at B+4. Up with post-step (upMode=1, preIndex=0) starts at B. Down with pre-step (upMode=0, preIndex=1) starts at B-4n. Down with post-step (upMode=0, preIndex=0) starts at B-4n+4.
- R3: In the cycle of `done`, `newBase` equals B+4n when counting up and B-4n when counting down. `baseWrEn` equals writeBack during `done` and is never high outside `done`.
- R4: On a store, the base register's slot carries the original base if the base register is the lowest listed index. If it is listed but not lowest and writeBack is set, the slot carries the updated base. Every other slot carries `rfRdData` for the index shown on `rfRdIdx`.
- R5: On a store, slot 15 carries instrAddr+12 in place of register data, and it is always the last access.
- R6: In the cycle of `done`, `cycleCost` equals 2n+1 for a load and 2n for a store.
- R7: An empty list produces `done` with no memory access. `memValid` is never high while `busy` is low, and both are low after reset.
- R8: While `memValid` is high and `memReady` is low, `memValid`, `memAddr`, `memRegIdx` and `memWdata` hold their values.
- R9: `memAddr` always has its two low bits at zero, even when the base address is unaligned.
- R10: On a load, each accepted access raises `rfWrEn` in the same cycle, with `rfWrIdx` equal to the access index and `rfWrData` equal to `memRdata`.
- R11: `done` is a single-cycle pulse. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken when not busy) |
| regList | input | 16 | Register list, bit i selects register i |
| baseAddr | input | 32 | Base address |
| baseIdx | input | 4 | Index of the base register |
| upMode | input | 1 | 1 = addresses above base, 0 = below |
| preIndex | input | 1 | Pre/post stepping selector |
| writeBack | input | 1 | Request base update |
| isLoad | input | 1 | 1 = load, 0 = store |
| instrAddr | input | 32 | Address of the issuing instruction |
| busy | output | 1 | Transfer in progress |
| memValid | output | 1 | Access request valid |
| memReady | input | 1 | Memory accepts the access |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 32 | Word-aligned access address |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data |
| memRegIdx | output | 4 | Register index of the access |
| rfRdIdx | output | 4 | Register file read index |
| rfRdData | input | 32 | Register file read data |
| rfWrEn | output | 1 | Register file write enable |
| rfWrIdx | output | 4 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| done | output | 1 | Transfer complete pulse |
| newBase | output | 32 | Updated base value, valid with done |
| baseWrEn | output | 1 | Write newBase to the base register |
| cycleCost | output | 6 | Nominal cycle cost, valid with done |

## Verification
The bench aims at the four start-address modes. A design that inverted the pre/post sense on down transfers would start one word off, and the first access address check would flag it. It also places the base register at the lowest listed position, at a higher position with and without write-back, and in slot 15. A design that chose the wrong substitution would store the updated base where the original belongs, or the reverse. Empty lists and random back-pressure from `memReady` expose a sequencer that issues stray accesses, drops or repeats a register under stall, or raises `done` early. A `start` strobe sent mid-transfer would corrupt the access sequence in a design that does not ignore it.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new transfer
    logic step;  // current access accepted, advance
  } xferCtl_t;
endpackage

// File: rtl/multi_reg_xfer_ctrl.sv
module multi_reg_xfer_ctrl
  import mrx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     maskEmpty,
  input  logic     memReady,
  output logic     busy,
  output logic     memValid,
  output logic     done,
  output xferCtl_t ctl
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateQ;
  logic   doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: if (start) stateQ <= ST_RUN;
        ST_RUN: begin
          if (maskEmpty) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (stateQ == ST_RUN);
    memValid = busy && !maskEmpty;
    ctl.load = (stateQ == ST_IDLE) && start;
    ctl.step = memValid && memReady;
  end

  assign done = doneQ;
endmodule

// File: rtl/multi_reg_xfer_dp.sv
module multi_reg_xfer_dp
  import mrx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NREGS     = 16,
  parameter int PC_OFFSET = 12,
  localparam int IDX_W    = $clog2(NREGS),
  localparam int CNT_W    = $clog2(NREGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCtl_t          ctl,
  input  logic [NREGS-1:0]  regList,
  input  logic [WORD_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              upMode,
  input  logic              preIndex,
  input  logic              writeBack,
  input  logic              isLoad,
  input  logic [WORD_W-1:0] instrAddr,
  input  logic [WORD_W-1:0] rfRdData,
  output logic              maskEmpty,
  output logic              loadMode,
  output logic [IDX_W-1:0]  curIdx,
  output logic [WORD_W-1:0] curAddr,
  output logic [WORD_W-1:0] storeData,
  output logic [WORD_W-1:0] newBase,
  output logic              wbEnable,
  output logic [CNT_W:0]    cycleCost
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int PC_IDX     = NREGS - 1;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [NREGS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [NREGS-1:0]  maskQ;
  logic [WORD_W-1:0] addrQ, baseQ, newBaseQ, pcQ;
  logic [IDX_W-1:0]  baseIdxQ;
  logic              baseFirstQ, wbQ, loadQ;
  logic [CNT_W-1:0]  nSetQ;

  // set-up values computed from the start fields
  logic [CNT_W-1:0]  nSet;
  logic [WORD_W-1:0] span, downBase, startAddr, endBase;
  logic              baseFirst;

  always_comb begin
    nSet      = CNT_W'($countones(regList));
    span      = WORD_W'(nSet) * STEP;
    downBase  = baseAddr - span;
    endBase   = upMode ? baseAddr + span : downBase;
    if (upMode) startAddr = preIndex ? baseAddr + STEP : baseAddr;
    else        startAddr = preIndex ? downBase : downBase + STEP;
    baseFirst = regList[baseIdx] && (lowestIdx(regList) == baseIdx);
  end

  // one-hot decode of the current index, used to retire it from the mask
  logic [NREGS-1:0] curOneHot;
  for (genvar g = 0; g < NREGS; g++) begin : g_dec
    assign curOneHot[g] = (curIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ      <= '0;
      addrQ      <= '0;
      baseQ      <= '0;
      newBaseQ   <= '0;
      pcQ        <= '0;
      baseIdxQ   <= '0;
      baseFirstQ <= 1'b0;
      wbQ        <= 1'b0;
      loadQ      <= 1'b0;
      nSetQ      <= '0;
    end else if (ctl.load) begin
      maskQ      <= regList;
      addrQ      <= startAddr;
      baseQ      <= baseAddr;
      newBaseQ   <= endBase;
      pcQ        <= instrAddr;
      baseIdxQ   <= baseIdx;
      baseFirstQ <= baseFirst;
      wbQ        <= writeBack;
      loadQ      <= isLoad;
      nSetQ      <= nSet;
    end else if (ctl.step) begin
      maskQ <= maskQ & ~curOneHot;
      addrQ <= addrQ + STEP;
    end
  end

  always_comb begin
    maskEmpty = (maskQ == '0);
    curIdx    = lowestIdx(maskQ);
    curAddr   = {addrQ[WORD_W-1:OFS_W], {OFS_W{1'b0}}};
    if (curIdx == IDX_W'(PC_IDX))
      storeData = pcQ + WORD_W'(PC_OFFSET);
    else if (curIdx == baseIdxQ && baseFirstQ)
      storeData = baseQ;
    else if (curIdx == baseIdxQ && wbQ)
      storeData = newBaseQ;
    else
      storeData = rfRdData;
  end

  assign loadMode  = loadQ;
  assign newBase   = newBaseQ;
  assign wbEnable  = wbQ;
  assign cycleCost = {nSetQ, loadQ};
endmodule

// File: rtl/multi_reg_xfer.sv
module multi_reg_xfer
  import mrx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NREGS     = 16,
  parameter int PC_OFFSET = 12,
  localparam int IDX_W    = $clog2(NREGS),
  localparam int CNT_W    = $clog2(NREGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NREGS-1:0]  regList,
  input  logic [WORD_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              upMode,
  input  logic              preIndex,
  input  logic              writeBack,
  input  logic              isLoad,
  input  logic [WORD_W-1:0] instrAddr,
  output logic              busy,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [IDX_W-1:0]  memRegIdx,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [WORD_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [WORD_W-1:0] rfWrData,
  output logic              done,
  output logic [WORD_W-1:0] newBase,
  output logic              baseWrEn,
  output logic [CNT_W:0]    cycleCost
);
  xferCtl_t          ctl;
  logic              maskEmpty, loadMode, wbEnable;
  logic [IDX_W-1:0]  curIdx;
  logic [WORD_W-1:0] storeData;

  multi_reg_xfer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maskEmpty (maskEmpty),
    .memReady  (memReady),
    .busy      (busy),
    .memValid  (memValid),
    .done      (done),
    .ctl       (ctl)
  );

  multi_reg_xfer_dp #(
    .WORD_W    (WORD_W),
    .NREGS     (NREGS),
    .PC_OFFSET (PC_OFFSET)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regList   (regList),
    .baseAddr  (baseAddr),
    .baseIdx   (baseIdx),
    .upMode    (upMode),
    .preIndex  (preIndex),
    .writeBack (writeBack),
    .isLoad    (isLoad),
    .instrAddr (instrAddr),
    .rfRdData  (rfRdData),
    .maskEmpty (maskEmpty),
    .loadMode  (loadMode),
    .curIdx    (curIdx),
    .curAddr   (memAddr),
    .storeData (storeData),
    .newBase   (newBase),
    .wbEnable  (wbEnable),
    .cycleCost (cycleCost)
  );

  assign memWrite  = memValid && !loadMode;
  assign memWdata  = loadMode ? '0 : storeData;
  assign memRegIdx = curIdx;
  assign rfRdIdx   = curIdx;
  assign rfWrEn    = ctl.step && loadMode;
  assign rfWrIdx   = curIdx;
  assign rfWrData  = memRdata;
  assign baseWrEn  = done && wbEnable;
endmodule

// File: rtl/multi_reg_xfer_chk.sv
module multi_reg_xfer_chk #(
  parameter int WORD_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS),
  localparam int OFS_W = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memValid,
  input logic              memReady,
  input logic [WORD_W-1:0] memAddr,
  input logic [IDX_W-1:0]  memRegIdx,
  input logic [WORD_W-1:0] memWdata,
  input logic              done,
  input logic              baseWrEn
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memAddr[OFS_W-1:0] == '0); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)
      && $stable(memRegIdx) && $stable(memWdata))); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memAddr == $past(memAddr) + STEP)); // R1

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memRegIdx > $past(memRegIdx))); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid); // R7

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> done); // R3
endmodule

bind multi_reg_xfer multi_reg_xfer_chk #(
  .WORD_W (WORD_W),
  .NREGS  (NREGS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .memValid  (memValid),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memRegIdx (memRegIdx),
  .memWdata  (memWdata),
  .done      (done),
  .baseWrEn  (baseWrEn)
);

// File: tb/multi_reg_xfer_tb_top.sv
module multi_reg_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic [3:0]  baseIdx = '0;
  logic        upMode = 1'b0, preIndex = 1'b0, writeBack = 1'b0, isLoad = 1'b0;
  logic [31:0] instrAddr = '0;
  logic        busy, memValid, memWrite, rfWrEn, done, baseWrEn;
  logic        memReady = 1'b0;
  logic [31:0] memAddr, memWdata, rfWrData, newBase, rfRdData;
  logic [31:0] memRdata = '0;
  logic [3:0]  memRegIdx, rfRdIdx, rfWrIdx;
  logic [5:0]  cycleCost;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rfModel(input logic [3:0] idx);
    return 32'h5A00_0000 ^ ({28'd0, idx} * 32'h0101_0101);
  endfunction

  assign rfRdData = rfModel(rfRdIdx);

  multi_reg_xfer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .regList(regList),
    .baseAddr(baseAddr), .baseIdx(baseIdx), .upMode(upMode),
    .preIndex(preIndex), .writeBack(writeBack), .isLoad(isLoad),
    .instrAddr(instrAddr), .busy(busy), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRegIdx(memRegIdx),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .done(done),
    .newBase(newBase), .baseWrEn(baseWrEn), .cycleCost(cycleCost)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) c++;
    return c;
  endfunction

  task automatic runXfer(input logic [15:0] lst, input logic [31:0] base,
                         input logic up, input logic pre, input logic wb,
                         input logic ld, input logic [3:0] bIdx,
                         input logic [31:0] pc, input int stall, input bit poke);
    int n, k, firstIdx;
    int order[16];
    logic [31:0] span, low, newB, expA, expD, holdAddr, holdData;
    logic [3:0] holdIdx;
    bit gotDone, holdV;
    string tag;
    n = 0; firstIdx = -1;
    for (int i = 0; i < 16; i++) if (lst[i]) begin
      order[n] = i; n++;
      if (firstIdx < 0) firstIdx = i;
    end
    span = 32'(n * 4);
    if (up) low = pre ? base + 32'd4 : base;
    else    low = pre ? base - span : base - span + 32'd4;
    newB = up ? base + span : base - span;

    @(negedge clk);
    regList = lst; baseAddr = base; baseIdx = bIdx; upMode = up;
    preIndex = pre; writeBack = wb; isLoad = ld; instrAddr = pc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; gotDone = 0; holdV = 0;
    holdAddr = '0; holdData = '0; holdIdx = '0;
    for (int cyc = 0; cyc < 400 && !gotDone; cyc++) begin
      if (cyc > 0) @(negedge clk);
      memReady = ($urandom_range(99) >= stall);
      memRdata = $urandom;
      if (poke && cyc == 0) begin
        // R11: start while busy must be ignored
        start = 1'b1; regList = 16'hFFFF; baseAddr = 32'h0BAD_0000;
        upMode = ~up; isLoad = ~ld;
      end else begin
        start = 1'b0;
      end
      #1;
      if (holdV) begin
        check(memValid && memAddr == holdAddr && memRegIdx == holdIdx
              && memWdata == holdData, "R8", "held access", memAddr, holdAddr);
      end
      holdV = memValid && !memReady;
      holdAddr = memAddr; holdIdx = memRegIdx; holdData = memWdata;
      if (memValid && memReady) begin
        if (k >= n) begin
          check(0, "R1", "extra access idx", {28'd0, memRegIdx}, 32'hFFFF_FFFF);
        end else begin
          expA = (low + 32'(k * 4)) & 32'hFFFF_FFFC;
          check(memRegIdx == 4'(order[k]), "R1", "access index",
                {28'd0, memRegIdx}, 32'(order[k]));
          tag = (k == 0) ? "R2" : "R1";
          check(memAddr == expA, tag, "access address", memAddr, expA);
          check(memAddr[1:0] == 2'b00, "R9", "alignment", memAddr, expA);
          check(memWrite == !ld, "R1", "write flag", {31'd0, memWrite}, {31'd0, !ld});
          if (!ld) begin
            if (order[k] == 15) begin
              expD = pc + 32'd12; tag = "R5";
            end else if (order[k] == bIdx) begin
              tag = "R4";
              if (firstIdx == bIdx) expD = base;
              else if (wb)          expD = newB;
              else                  expD = rfModel(bIdx);
            end else begin
              expD = rfModel(4'(order[k])); tag = "R4";
            end
            check(memWdata == expD, tag, "store data", memWdata, expD);
          end else begin
            check(rfWrEn && rfWrIdx == 4'(order[k]) && rfWrData == memRdata,
                  "R10", "load writeback", rfWrData, memRdata);
          end
        end
        k++;
      end else if (ld) begin
        check(!rfWrEn, "R10", "no write without handshake", {31'd0, rfWrEn}, 32'd0);
      end
      if (done) begin
        gotDone = 1;
        check(k == n, (n == 0) ? "R7" : "R1", "access count", 32'(k), 32'(n));
        check(newBase == newB, "R3", "newBase", newBase, newB);
        check(baseWrEn == wb, "R3", "baseWrEn", {31'd0, baseWrEn}, {31'd0, wb});
        check(cycleCost == 6'(2 * n + int'(ld)), "R6", "cycle cost",
              {26'd0, cycleCost}, 32'(2 * n + int'(ld)));
      end
    end
    start = 1'b0;
    if (!gotDone) check(0, "R11", "done never seen", 32'd0, 32'd1);
    @(negedge clk);
    #1;
    check(!done, "R11", "done is one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R11", "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    #1;
    check(!memValid && !busy && !done, "R7", "reset state",
          {29'd0, memValid, busy, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!memValid && !busy && !done, "R7", "idle after reset",
          {29'd0, memValid, busy, done}, 32'd0);

    // four address modes, full and partial lists
    runXfer(16'hFFFF, 32'h0000_1000, 1, 0, 1, 0, 4'd0, 32'h0000_8000, 0, 0);
    runXfer(16'h00F0, 32'h0000_2000, 1, 1, 1, 1, 4'd2, 32'h0, 20, 0);
    runXfer(16'h8421, 32'h0000_3000, 0, 1, 1, 0, 4'd13, 32'h0000_4440, 20, 0);
    runXfer(16'h0F0F, 32'h0000_3000, 0, 0, 0, 1, 4'd1, 32'h0, 20, 0);
    // empty lists
    runXfer(16'h0000, 32'h0000_5000, 1, 1, 1, 1, 4'd3, 32'h0, 0, 0);
    runXfer(16'h0000, 32'h0000_5000, 0, 0, 0, 0, 4'd3, 32'h0, 0, 0);
    // base register slot on stores
    runXfer(16'h0038, 32'h0000_6000, 1, 0, 1, 0, 4'd3, 32'h0, 0, 0);
    runXfer(16'h0038, 32'h0000_6000, 1, 0, 1, 0, 4'd4, 32'h0, 0, 0);
    runXfer(16'h0038, 32'h0000_6000, 0, 1, 0, 0, 4'd5, 32'h0, 0, 0);
    // program-counter slot only, unaligned base, heavy stall
    runXfer(16'h8000, 32'h0000_7003, 1, 1, 0, 0, 4'd9, 32'h0001_0004, 60, 0);
    runXfer(16'h8000, 32'h0000_7002, 0, 0, 1, 1, 4'd9, 32'h0, 60, 0);
    // start while busy
    runXfer(16'h0606, 32'h0000_9000, 1, 1, 0, 0, 4'd2, 32'h0, 40, 1);

    for (int t = 0; t < 400; t++) begin
      runXfer(16'($urandom), $urandom, 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 4'($urandom), $urandom, 30,
              (t % 7) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule